// File: doc/BRIEF.md
# Static memory strobe timing controller

This block runs single accesses to one external static memory device. An internal agent raises a request with direction, address, write data and byte enables. The block then plays out one access cycle and shapes the chip-select, read-strobe and per-lane write-strobe pins from timing values counted in clock cycles. Each strobe has its own setup offset and pulse width. Reads and writes each have their own total cycle length.

Read data is captured at the rising edge of either the chip select or the read strobe. Write data is driven starting at the falling edge of either the chip select or the write strobe. A wait input from the memory can freeze the whole access, or it can hold the data strobe low until the device reports ready. After a read, a programmable data-float gap keeps the bus quiet so the memory can release it. This gap can be skipped when the next access is also a read. The timing inputs are treated as static while an access or float gap is in progress.

Top module: `smc_strobe_ctrl`

## Requirements
- R1: After reset, chip select, read strobe and every write-strobe and byte-enable lane are high, data output enable is low, and the acknowledge is low.
- R2: Let k count the access cycles from 0. Chip select is low exactly when setup <= k < min(setup + pulse, L). The setup and pulse values are the read pair or the write pair, chosen by the access direction. The request address is shown on the address pins throughout the access.
- R3: The data strobe follows the same rule with its own setup and pulse counts. It is the read strobe for reads and the write strobe for writes, and the strobe of the other direction stays high.
- R4: An access lasts L cycles. L is the cycle length of its direction, or 1 when that length is 0. A window that runs past L is clipped, so every strobe is high again after cycle L-1.
- R5: The acknowledge is high for exactly one cycle, in the cycle just after the last access cycle. A request that is held high is accepted only while the block is idle and not acknowledging.
- R6: For a read, the read-sample bit chooses the captured data. When it is 0, the capture is the input data of the last cycle with chip select low. When it is 1, it is the input data of the last cycle with the read strobe low. The captured data is on the read-data output when the acknowledge is high.
- R7: For a write, the output enable is high from k equal to the write chip-select setup (drive-select bit 0), or from k equal to the write-strobe setup (bit 1), until the end of the access. During that time the data pins carry the write data.
- R8: In wait mode 2 (freeze), each access cycle with the wait input high holds every strobe level and the cycle count. This makes the access one cycle longer.
- R9: In wait mode 3 (ready), wait is looked at only in the last low cycle of the data strobe. While wait is high there, the strobe stays low and the count holds. When wait falls, the rest of the cycle completes.
- R10: In wait modes 0 and 1, the wait input has no effect on strobes, timing or data.
- R11: Lane style bit 0 (shared selects): each byte-enable lane is low through the whole access when its request enable is set, and all write-strobe lanes move together. Lane style bit 1 (per-lane writes): the byte enables stay high, and write-strobe lane i goes low only when request enable bit i is set.
- R12: After a read, with float count F, the next access starts no earlier than F+1 idle cycles after the acknowledge cycle. Its first cycle is then at least ack + F + 2. When the skip bit is set, a following read is not delayed this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | 8*LANES | Write data |
| req_be_i | input | LANES | Byte-lane enables |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8*LANES | Captured read data |
| cs_rd_setup_i | input | CNT_W | Chip-select setup, reads |
| rd_setup_i | input | CNT_W | Read-strobe setup |
| cs_wr_setup_i | input | CNT_W | Chip-select setup, writes |
| wr_setup_i | input | CNT_W | Write-strobe setup |
| cs_rd_pulse_i | input | CNT_W | Chip-select pulse, reads |
| rd_pulse_i | input | CNT_W | Read-strobe pulse |
| cs_wr_pulse_i | input | CNT_W | Chip-select pulse, writes |
| wr_pulse_i | input | CNT_W | Write-strobe pulse |
| rd_cycle_i | input | CNT_W | Read cycle length |
| wr_cycle_i | input | CNT_W | Write cycle length |
| rd_on_strobe_i | input | 1 | Read sample edge: 0 chip select, 1 read strobe |
| wr_on_strobe_i | input | 1 | Write drive start: 0 chip select, 1 write strobe |
| wait_mode_i | input | 2 | 0/1 ignore, 2 freeze, 3 ready |
| lane_strobe_i | input | 1 | 0 shared selects, 1 per-lane write strobes |
| float_cnt_i | input | FLT_W | Data-float count after reads |
| float_skip_i | input | 1 | Skip float gap before a read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_we_no | output | LANES | Write strobes, active low |
| mem_be_no | output | LANES | Byte selects, active low |
| mem_dq_o | output | 8*LANES | Data out |
| mem_dq_oe_o | output | 1 | Data output enable |
| mem_dq_i | input | 8*LANES | Data in |
| mem_wait_i | input | 1 | Wait request from memory, active high |

## Verification
A wrong internal cycle count shows at the ports within the same access. The strobe edges move away from their expected cycle offsets, and the acknowledge arrives early or late. A wrong capture point returns input data from a different cycle. Because the bench drives data that changes every cycle, this shows on the very acknowledge of that read. A stuck float timer shows on the next access after a read, as a first chip-select cycle that comes too soon or too late.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    WM_OFF    = 2'd0,
    WM_RSVD   = 2'd1,
    WM_FREEZE = 2'd2,
    WM_READY  = 2'd3
  } wait_mode_e;
endpackage

// File: rtl/smc_strobe_win.sv
module smc_strobe_win #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] pulse_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             past_o,
  output logic             act_o,
  output logic             last_o
);
  logic [CNT_W:0] sum, lim, stop;

  always_comb begin
    sum    = {1'b0, setup_i} + {1'b0, pulse_i};
    lim    = (len_i == '0) ? (CNT_W+1)'(1) : {1'b0, len_i};
    stop   = (sum > lim) ? lim : sum;  // clip to cycle end
    past_o = cnt_i >= setup_i;
    act_o  = past_o && ({1'b0, cnt_i} < stop);
    last_o = act_o && ({1'b0, cnt_i} == stop - 1'b1);
  end
endmodule

// File: rtl/smc_cycle_seq.sv
module smc_cycle_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stall_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = (len_i == '0) ? '0 : len_i - 1'b1;
  assign done_o   = run_o && !stall_i && (cnt_o == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (start_i) begin
      run_o <= 1'b1;
      cnt_o <= '0;
    end else if (run_o && !stall_i) begin
      if (cnt_o == last_cnt) run_o <= 1'b0;
      else                   cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/smc_float_tmr.sv
module smc_float_tmr #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [FLT_W-1:0] len_i,
  output logic             busy_o
);
  localparam int FW = FLT_W + 1;
  logic [FW-1:0] fcnt;

  assign busy_o = fcnt != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fcnt <= '0;
    else if (load_i)  fcnt <= {1'b0, len_i} + 1'b1;
    else if (busy_o)  fcnt <= fcnt - 1'b1;
  end
endmodule

// File: rtl/smc_strobe_ctrl.sv
module smc_strobe_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int CNT_W  = 8,
  parameter int FLT_W  = 4,
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cs_rd_setup_i,
  input  logic [CNT_W-1:0]  rd_setup_i,
  input  logic [CNT_W-1:0]  cs_wr_setup_i,
  input  logic [CNT_W-1:0]  wr_setup_i,
  input  logic [CNT_W-1:0]  cs_rd_pulse_i,
  input  logic [CNT_W-1:0]  rd_pulse_i,
  input  logic [CNT_W-1:0]  cs_wr_pulse_i,
  input  logic [CNT_W-1:0]  wr_pulse_i,
  input  logic [CNT_W-1:0]  rd_cycle_i,
  input  logic [CNT_W-1:0]  wr_cycle_i,
  input  logic              rd_on_strobe_i,
  input  logic              wr_on_strobe_i,
  input  logic [1:0]        wait_mode_i,
  input  logic              lane_strobe_i,
  input  logic [FLT_W-1:0]  float_cnt_i,
  input  logic              float_skip_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_rd_no,
  output logic [LANES-1:0]  mem_we_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_wait_i
);
  localparam int N_WIN = 2;  // 0: chip select, 1: data strobe

  wait_mode_e        wmode;
  logic              run, start, stall, done, capture, flt_busy, wstrobe;
  logic              ack_q, we_q;
  logic [CNT_W-1:0]  cnt, cyc_len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  be_q;
  logic [CNT_W-1:0]  win_set [N_WIN];
  logic [CNT_W-1:0]  win_pul [N_WIN];
  logic [N_WIN-1:0]  win_past, win_act, win_last;

  assign wmode      = wait_mode_e'(wait_mode_i);
  assign cyc_len    = we_q ? wr_cycle_i    : rd_cycle_i;
  assign win_set[0] = we_q ? cs_wr_setup_i : cs_rd_setup_i;
  assign win_pul[0] = we_q ? cs_wr_pulse_i : cs_rd_pulse_i;
  assign win_set[1] = we_q ? wr_setup_i    : rd_setup_i;
  assign win_pul[1] = we_q ? wr_pulse_i    : rd_pulse_i;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    smc_strobe_win #(.CNT_W(CNT_W)) u_win (
      .cnt_i   (cnt),
      .setup_i (win_set[g]),
      .pulse_i (win_pul[g]),
      .len_i   (cyc_len),
      .past_o  (win_past[g]),
      .act_o   (win_act[g]),
      .last_o  (win_last[g])
    );
  end

  assign start = req_i && !run && !ack_q && (!flt_busy || (float_skip_i && !req_we_i));

  always_comb begin
    unique case (wmode)
      WM_FREEZE: stall = run && mem_wait_i;
      WM_READY:  stall = run && mem_wait_i && win_last[1];
      default:   stall = 1'b0;
    endcase
  end

  assign capture = run && !we_q && !stall && (rd_on_strobe_i ? win_last[1] : win_last[0]);

  smc_cycle_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .stall_i (stall),
    .len_i   (cyc_len),
    .run_o   (run),
    .cnt_o   (cnt),
    .done_o  (done)
  );

  smc_float_tmr #(.FLT_W(FLT_W)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done && !we_q),
    .len_i  (float_cnt_i),
    .busy_o (flt_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= done;
      if (start) begin
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign wstrobe = run && we_q && win_act[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_we_no[l] = !(wstrobe && (!lane_strobe_i || be_q[l]));
    assign mem_be_no[l] = !(run && !lane_strobe_i && be_q[l]);
  end

  assign mem_cs_no   = !(run && win_act[0]);
  assign mem_rd_no   = !(run && !we_q && win_act[1]);
  assign mem_dq_oe_o = run && we_q && (wr_on_strobe_i ? win_past[1] : win_past[0]);
  assign mem_dq_o    = wdata_q;
  assign mem_addr_o  = addr_q;
  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/smc_strobe_ctrl_chk.sv
module smc_strobe_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_o,
  input logic             mem_cs_no,
  input logic             mem_rd_no,
  input logic [LANES-1:0] mem_we_no,
  input logic [LANES-1:0] mem_be_no,
  input logic             mem_dq_oe_o,
  input logic [1:0]       wait_mode_i,
  input logic             lane_strobe_i,
  input logic             mem_wait_i
);
  // R5
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R4
  ack_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (mem_cs_no && mem_rd_no && (&mem_we_no) && !mem_dq_oe_o));

  // R3
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !(&mem_we_no)));

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_rd_no);

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_mode_i == 2'd2 && mem_wait_i && !mem_cs_no)
      |=> ($stable(mem_cs_no) && $stable(mem_rd_no) && $stable(mem_we_no)));

  // R11
  lane_sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_strobe_i |-> (&mem_be_no));
endmodule

bind smc_strobe_ctrl smc_strobe_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ack_o         (ack_o),
  .mem_cs_no     (mem_cs_no),
  .mem_rd_no     (mem_rd_no),
  .mem_we_no     (mem_we_no),
  .mem_be_no     (mem_be_no),
  .mem_dq_oe_o   (mem_dq_oe_o),
  .wait_mode_i   (wait_mode_i),
  .lane_strobe_i (lane_strobe_i),
  .mem_wait_i    (mem_wait_i)
);

// File: tb/smc_strobe_ctrl_test.sv
module smc_strobe_ctrl_test;
  localparam int AW = 16, LN = 2, DW = 16, CW = 8, FW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LN-1:0] req_be = '0;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [CW-1:0] cs_rd_set = 1, rd_set = 2, cs_wr_set = 0, wr_set = 1;
  logic [CW-1:0] cs_rd_pul = 5, rd_pul = 3, cs_wr_pul = 6, wr_pul = 4;
  logic [CW-1:0] rd_cyc = 7, wr_cyc = 7;
  logic          rd_on_str = 0, wr_on_str = 0, lane_str = 0, fskip = 0;
  logic [1:0]    wmode = 0;
  logic [FW-1:0] fl = 0;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_rd_n, mem_oe, mem_wait = 0;
  logic [LN-1:0] mem_we_n, mem_be_n;
  logic [DW-1:0] mem_dq_o, mem_dq_i = '0;

  smc_strobe_ctrl #(.ADDR_W(AW), .LANES(LN), .CNT_W(CW), .FLT_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .ack_o(ack), .rdata_o(rdata),
    .cs_rd_setup_i(cs_rd_set), .rd_setup_i(rd_set), .cs_wr_setup_i(cs_wr_set),
    .wr_setup_i(wr_set), .cs_rd_pulse_i(cs_rd_pul), .rd_pulse_i(rd_pul),
    .cs_wr_pulse_i(cs_wr_pul), .wr_pulse_i(wr_pul), .rd_cycle_i(rd_cyc),
    .wr_cycle_i(wr_cyc), .rd_on_strobe_i(rd_on_str), .wr_on_strobe_i(wr_on_str),
    .wait_mode_i(wmode), .lane_strobe_i(lane_str), .float_cnt_i(fl),
    .float_skip_i(fskip), .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n),
    .mem_rd_no(mem_rd_n), .mem_we_no(mem_we_n), .mem_be_no(mem_be_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_oe), .mem_dq_i(mem_dq_i),
    .mem_wait_i(mem_wait)
  );

  typedef struct {
    int            cyc;
    logic          wt;
    logic          cs;
    logic          rd;
    logic [LN-1:0] we;
    logic [LN-1:0] be;
    logic          oe;
    logic          ack;
    logic          chk_rd;
    logic [DW-1:0] rdv;
    logic [AW-1:0] adr;
    logic [DW-1:0] wd;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    total = 0, bad = 0, cyc = 0;
  int    last_ack = 0;
  logic  last_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] dqf(int c);
    return DW'(c * 29 + 961);
  endfunction

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d act=%h exp=%h", tg, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: drives memory-side inputs, pops and compares expected items
  initial begin
    forever begin
      @(negedge clk);
      mem_dq_i = dqf(cyc);
      mem_wait = 1'b0;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t  e;
        string tg;
        e  = q.pop_front();
        tg = tq.pop_front();
        mem_wait = e.wt;
        chk(tg, "cs", 32'(mem_cs_n), 32'(e.cs));
        chk(tg, "rd", 32'(mem_rd_n), 32'(e.rd));
        chk(tg, "we", 32'(mem_we_n), 32'(e.we));
        chk(tg, "be", 32'(mem_be_n), 32'(e.be));
        chk(tg, "oe", 32'(mem_oe), 32'(e.oe));
        chk(tg, "ack", 32'(ack), 32'(e.ack));
        if (!e.ack) chk(tg, "addr", 32'(mem_addr), 32'(e.adr));
        if (e.oe) chk(tg, "dq", 32'(mem_dq_o), 32'(e.wd));
        if (e.chk_rd) chk(tg, "rdata", 32'(rdata), 32'(e.rdv));
      end
    end
  end

  // driver: predicts the access cycle by cycle, queues it, then issues it
  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [LN-1:0] b, input int wst, input int wln, input string tg);
    int t, s, n, c, len, css, csp, dset, dpul, ce, de, oes, gate;
    logic stl, clo, dlo, w;
    logic [DW-1:0] rv;
    exp_t e;
    @(negedge clk);
    t = cyc;
    if (last_rd && (we || !fskip)) begin
      gate = last_ack + int'(fl) + 1;
      s = ((t > gate) ? t : gate) + 1;  // R12 float gap
    end else s = t + 1;
    len  = we ? int'(wr_cyc) : int'(rd_cyc);
    if (len == 0) len = 1;
    css  = we ? int'(cs_wr_set) : int'(cs_rd_set);
    csp  = we ? int'(cs_wr_pul) : int'(cs_rd_pul);
    dset = we ? int'(wr_set) : int'(rd_set);
    dpul = we ? int'(wr_pul) : int'(rd_pul);
    ce   = (css + csp > len) ? len : css + csp;
    de   = (dset + dpul > len) ? len : dset + dpul;
    oes  = wr_on_str ? dset : css;
    c = 0; n = 0; rv = rdata;
    for (int i = 0; i < 1000; i++) begin
      w   = (i >= wst) && (i < wst + wln);
      clo = (c >= css) && (c < ce);
      dlo = (c >= dset) && (c < de);
      if (wmode == 2)      stl = w;
      else if (wmode == 3) stl = w && dlo && (c == de - 1);
      else                 stl = 1'b0;
      e.cyc = s + i; e.wt = w; e.cs = !clo; e.rd = !(!we && dlo);
      for (int l = 0; l < LN; l++) begin
        e.we[l] = !(we && dlo && (!lane_str || b[l]));
        e.be[l] = !(!lane_str && b[l]);
      end
      e.oe = we && (c >= oes); e.ack = 0; e.chk_rd = 0; e.rdv = '0; e.adr = a; e.wd = d;
      if (!we && !stl && (rd_on_str ? dlo : clo)) rv = dqf(s + i);
      q.push_back(e); tq.push_back(tg);
      if (!stl) begin
        if (c == len - 1) begin n = i + 1; break; end
        c++;
      end
    end
    e.cyc = s + n; e.wt = 0; e.cs = 1; e.rd = 1; e.we = '1; e.be = '1; e.oe = 0; e.ack = 1;
    e.chk_rd = !we; e.rdv = rv;
    q.push_back(e); tq.push_back(tg);
    req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = b;
    do @(negedge clk); while (cyc != s + n);
    req = 0;
    last_ack = s + n;
    last_rd  = !we;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R5 act=hung exp=complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs", 32'(mem_cs_n), 1);
    chk("R1", "rd", 32'(mem_rd_n), 1);
    chk("R1", "we", 32'(mem_we_n), 32'h3);
    chk("R1", "be", 32'(mem_be_n), 32'h3);
    chk("R1", "oe", 32'(mem_oe), 0);
    chk("R1", "ack", 32'(ack), 0);

    issue(0, 16'h1234, '0, 2'b11, 0, 0, "R2 R3 R5 R6 R11 read cs-sample");
    rd_on_str = 1;
    issue(0, 16'h0055, '0, 2'b01, 0, 0, "R6 read strobe-sample");
    issue(1, 16'h0A0A, 16'hBEEF, 2'b01, 0, 0, "R7 R11 write shared selects");
    lane_str = 1; wr_on_str = 1;
    issue(1, 16'h0B0B, 16'hC0DE, 2'b10, 0, 0, "R7 R11 write per-lane");
    lane_str = 0;
    cs_rd_set = 0; cs_rd_pul = 20; rd_set = 2; rd_pul = 9; rd_cyc = 6;
    issue(0, 16'h0100, '0, 2'b11, 0, 0, "R4 clipped read");
    wr_cyc = 0; cs_wr_set = 0; cs_wr_pul = 3; wr_set = 0; wr_pul = 2;
    issue(1, 16'h0200, 16'h1111, 2'b11, 0, 0, "R4 zero-length write");
    cs_rd_set = 1; cs_rd_pul = 5; rd_set = 2; rd_pul = 3; rd_cyc = 7;
    cs_wr_set = 0; cs_wr_pul = 6; wr_set = 1; wr_pul = 4; wr_cyc = 7;
    wmode = 2;
    issue(0, 16'h0300, '0, 2'b11, 2, 3, "R8 frozen read");
    issue(1, 16'h0301, 16'h2222, 2'b11, 3, 2, "R8 frozen write");
    wmode = 3;
    issue(0, 16'h0400, '0, 2'b11, 3, 3, "R9 ready read");
    issue(1, 16'h0401, 16'h3333, 2'b01, 0, 4, "R9 ready write");
    wmode = 1;
    issue(0, 16'h0500, '0, 2'b11, 0, 10, "R10 reserved mode read");
    wmode = 0;
    issue(1, 16'h0501, 16'h4444, 2'b11, 0, 10, "R10 ignored wait write");
    fl = 3;
    issue(0, 16'h0600, '0, 2'b11, 0, 0, "R12 read before gap");
    issue(1, 16'h0601, 16'h5555, 2'b11, 0, 0, "R12 write after read");
    fl = 2;
    issue(0, 16'h0602, '0, 2'b11, 0, 0, "R12 read");
    issue(0, 16'h0603, '0, 2'b11, 0, 0, "R12 read after read no skip");
    fskip = 1;
    issue(0, 16'h0604, '0, 2'b11, 0, 0, "R12 read after read skip");
    issue(1, 16'h0605, 16'h6666, 2'b10, 0, 0, "R12 write after read skip");
    repeat (4) @(negedge clk);
    chk("R5", "queue drained", 32'(q.size()), 0);
    summary();
    $finish;
  end
endmodule